// File: doc/BRIEF.md
# Pseudo-SRAM Device Control Model

This block is a clocked, synthesizable model of the control side of a 16-bit pseudo-static RAM with two byte lanes. It samples the active-low chip select, write enable, output enable and the two byte selects, plus an active-high mode pin, once per clock. From these it decides for each lane whether to write, read, stay quiet, or go to standby. A small internal word array stands in for the cell array. There are no tri-state pins. The model reports, for each lane, whether that lane would be driving the bus, and it returns the read data with one cycle of latency.

The model also follows the power sequence of the device. After reset it waits a configurable number of clock cycles. It then needs three dummy reads, each one closed by a rising chip select, before it accepts any access. When deselected it parks in one of two standbys. With mode high it keeps its data. With mode low it enters deep standby and discards all stored data. Leaving deep standby repeats the full power-on recovery. A read flag tells whether every lane that was read held data written since the last time the array was invalidated.

The power-controller states are named as follows:
- Initialisation has two internal phases, WAIT and DUMMY.
- ACTIVE means selected and ready.
- RETAIN means deselected with data kept.
- DEEP means deselected with data lost.

The transitions between them are:
- WAIT→DUMMY when the wait count expires.
- DUMMY→RETAIN on the third rising chip select.
- ACTIVE→RETAIN and RETAIN→ACTIVE by chip select.
- ACTIVE/RETAIN→DEEP when mode goes low while deselected.
- WAIT/DUMMY→DEEP when mode goes low during initialisation.
- DEEP→WAIT when mode returns high.

Top module: `psram_ctrl_model`

## Requirements
- R1: During and just after reset, `status` is 0 (initialising), both lane drive flags are low and `rd_ok` is low.
- R2: While `status` is 0, no access takes effect. Rising chip-select edges that occur before `WAIT_CYCLES` cycles have passed are not counted. After the wait, `status` stays 0 until the third rising edge of `cs_n`, and becomes 2 after it. A write attempted during initialisation is lost.
- R3: A write happens when chip select is low, mode is high and write enable is low, once initialisation is done. Lane 0 (`wdata[7:0]`) is written only if `lb_n` is low, and lane 1 (`wdata[15:8]`) only if `ub_n` is low. With both selects high the write is aborted and the stored word is unchanged.
- R4: A read happens when chip select is low, write enable is high and output enable is low. In the cycle after, each lane whose select was low has its drive flag set and carries the stored byte. A lane whose select was high has its drive flag clear and reads 0.
- R5: With chip select low and both output enable and write enable high, neither lane drives in the following cycle.
- R6: While write enable is low, no lane drives in the following cycle, even with output enable low.
- R7: One cycle after chip select is low, `status` is 1 (active). One cycle after it is high with mode high, `status` is 2 (standby, data kept), and neither lane drives.
- R8: Mode low with chip select high moves `status` to 3 (deep standby) in the next cycle and invalidates every stored byte. A later read of an invalidated byte returns 0 on that lane with `rd_ok` low, until that byte is written again.
- R9: From `status` 3, mode high moves `status` to 0 in the next cycle, and the full wait plus three dummy reads is needed again. Mode low at any point during initialisation moves `status` to 3.
- R10: Data written before a data-keeping standby reads back unchanged after it.
- R11: `rd_ok` is high exactly when at least one lane drives and every driving lane read a byte written since the last invalidation or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| cs_n | input | 1 | Chip select, active low |
| mode | input | 1 | High: keep data in standby; low: deep standby |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte lane select, active low |
| ub_n | input | 1 | Upper byte lane select, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero on lanes not driving or invalid |
| drv_lo | output | 1 | Lower lane would drive the bus |
| drv_hi | output | 1 | Upper lane would drive the bus |
| rd_ok | output | 1 | All driving lanes returned valid data |
| status | output | 2 | 0 init, 1 active, 2 standby kept, 3 deep standby |

## Verification
A controller stuck in or wrongly leaving initialisation shows on `status` within one cycle of the deciding chip-select or mode edge. It also shows on the first read after that edge: the lanes either drive when they should stay quiet, or stay quiet when they should drive. A missed invalidation is silent until a byte from before deep standby is read back. At that point `rd_ok` is high or the byte is non-zero, so the bench reads back old addresses right after each recovery. Lane decoding errors appear one cycle after the access, on the drive flags and on the byte contents of the next read of that word.

// File: rtl/psram_pkg.sv
package psram_pkg;

    // Externally visible status codes
    typedef enum logic [1:0] {
        PS_INIT   = 2'd0,
        PS_ACTIVE = 2'd1,
        PS_RETAIN = 2'd2,
        PS_LOST   = 2'd3
    } psram_status_e;

    // Internal power controller states
    typedef enum logic [2:0] {
        F_WAIT   = 3'd0,
        F_DUMMY  = 3'd1,
        F_ACTIVE = 3'd2,
        F_RETAIN = 3'd3,
        F_DEEP   = 3'd4
    } psram_fsm_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/psram_power_fsm.sv
module psram_power_fsm
    import psram_pkg::*;
#(
    parameter int WAIT_CYCLES = 40,
    parameter int DUMMY_READS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       mode,
    output logic       ready,
    output logic       wipe,
    output logic [1:0] status
);

    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam int DW_CNT = $clog2(DUMMY_READS + 1);

    psram_fsm_e state, next;
    logic [CW-1:0]     wait_cnt;
    logic [DW_CNT-1:0] dummy_cnt;
    logic              cs_q;
    logic              cs_rise;
    logic              wait_done;
    logic              last_dummy;

    assign cs_rise    = cs_n && !cs_q;
    assign wait_done  = (wait_cnt == CW'(WAIT_CYCLES - 1));
    assign last_dummy = (dummy_cnt == DW_CNT'(DUMMY_READS - 1));

    // Next-state decision
    always_comb begin
        next = state;
        unique case (state)
            F_WAIT: begin
                if (!mode)          next = F_DEEP;
                else if (wait_done) next = F_DUMMY;
            end
            F_DUMMY: begin
                if (!mode)                     next = F_DEEP;
                else if (cs_rise && last_dummy) next = F_RETAIN;
            end
            F_ACTIVE: begin
                if (cs_n) next = mode ? F_RETAIN : F_DEEP;
            end
            F_RETAIN: begin
                if (cs_n && !mode)      next = F_DEEP;
                else if (!cs_n && mode) next = F_ACTIVE;
            end
            F_DEEP: begin
                if (mode) next = F_WAIT;
            end
            default: next = F_WAIT;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= F_WAIT;
            wait_cnt  <= '0;
            dummy_cnt <= '0;
            cs_q      <= 1'b1;
        end else begin
            state <= next;
            cs_q  <= cs_n;
            if (state == F_WAIT && next == F_WAIT)
                wait_cnt <= wait_cnt + 1'b1;
            else
                wait_cnt <= '0;
            if (state == F_DUMMY && next == F_DUMMY) begin
                if (cs_rise) dummy_cnt <= dummy_cnt + 1'b1;
            end else begin
                dummy_cnt <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        ready = 1'b0;
        unique case (state)
            F_WAIT, F_DUMMY: status = PS_INIT;
            F_ACTIVE: begin
                status = PS_ACTIVE;
                ready  = 1'b1;
            end
            F_RETAIN: begin
                status = PS_RETAIN;
                ready  = 1'b1;
            end
            F_DEEP:   status = PS_LOST;
            default:  status = PS_INIT;
        endcase
        wipe = (next == F_DEEP) && (state != F_DEEP);
    end

endmodule

// File: rtl/psram_pin_decode.sv
module psram_pin_decode #(
    parameter int LANES = 2
) (
    input  logic             ready,
    input  logic             cs_n,
    input  logic             mode,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [LANES-1:0] sel_n,
    output logic [LANES-1:0] wr,
    output logic [LANES-1:0] rd
);

    logic access;

    always_comb begin
        access = ready && !cs_n && mode;
        wr     = (access && !we_n)         ? ~sel_n : '0;
        rd     = (access && we_n && !oe_n) ? ~sel_n : '0;
    end

endmodule

// File: rtl/psram_store.sv
module psram_store
    import psram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic [DW/LANE_W-1:0]    wr,
    input  logic [DW/LANE_W-1:0]    rd,
    input  logic                    wipe,
    output logic [DW-1:0]           rdata,
    output logic [DW/LANE_W-1:0]    drv,
    output logic [DW/LANE_W-1:0]    ok
);

    localparam int LANES = DW / LANE_W;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [DEPTH-1:0]  vld;
        logic              drv_r;
        logic              ok_r;
        logic [LANE_W-1:0] dat_r;

        always_ff @(posedge clk) begin
            if (wr[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld   <= '0;
                drv_r <= 1'b0;
                ok_r  <= 1'b1;
                dat_r <= '0;
            end else begin
                if (wipe)       vld       <= '0;
                else if (wr[g]) vld[addr] <= 1'b1;
                drv_r <= rd[g];
                ok_r  <= !rd[g] || vld[addr];
                dat_r <= (rd[g] && vld[addr]) ? mem[addr] : '0;
            end
        end

        assign drv[g]                       = drv_r;
        assign ok[g]                        = ok_r;
        assign rdata[g*LANE_W +: LANE_W]    = dat_r;
    end

endmodule

// File: rtl/psram_ctrl_model.sv
module psram_ctrl_model
    import psram_pkg::*;
#(
    parameter int AW          = 4,
    parameter int DW          = 16,
    parameter int WAIT_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          mode,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          lb_n,
    input  logic          ub_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          drv_lo,
    output logic          drv_hi,
    output logic          rd_ok,
    output logic [1:0]    status
);

    localparam int LANES = DW / LANE_W;

    logic             ready;
    logic             wipe;
    logic [LANES-1:0] wr_l;
    logic [LANES-1:0] rd_l;
    logic [LANES-1:0] drv_l;
    logic [LANES-1:0] ok_l;

    psram_power_fsm #(
        .WAIT_CYCLES (WAIT_CYCLES),
        .DUMMY_READS (3)
    ) i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .mode   (mode),
        .ready  (ready),
        .wipe   (wipe),
        .status (status)
    );

    psram_pin_decode #(
        .LANES (LANES)
    ) i_dec (
        .ready (ready),
        .cs_n  (cs_n),
        .mode  (mode),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .sel_n ({ub_n, lb_n}),
        .wr    (wr_l),
        .rd    (rd_l)
    );

    psram_store #(
        .AW (AW),
        .DW (DW)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr    (wr_l),
        .rd    (rd_l),
        .wipe  (wipe),
        .rdata (rdata),
        .drv   (drv_l),
        .ok    (ok_l)
    );

    assign drv_lo = drv_l[0];
    assign drv_hi = drv_l[LANES-1];
    assign rd_ok  = (|drv_l) && (&ok_l);

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       mode,
    input logic       we_n,
    input logic       drv_lo,
    input logic       drv_hi,
    input logic       rd_ok,
    input logic [1:0] status
);

    assert_init_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd0) |=> !(drv_lo || drv_hi));

    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !(drv_lo || drv_hi));

    assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(drv_lo || drv_hi));

    assert_enter_deep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2 && cs_n && !mode) |=> (status == 2'd3));

    assert_leave_deep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd3 && mode) |=> (status == 2'd0));

    assert_ok_needs_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> (drv_lo || drv_hi));

endmodule

bind psram_ctrl_model psram_ctrl_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .mode   (mode),
    .we_n   (we_n),
    .drv_lo (drv_lo),
    .drv_hi (drv_hi),
    .rd_ok  (rd_ok),
    .status (status)
);

// File: tb/test_psram_ctrl_model.sv
module test_psram_ctrl_model;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int WAITC = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n, mode, oe_n, we_n, lb_n, ub_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          drv_lo, drv_hi, rd_ok;
    logic [1:0]    status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model of the storage
    logic [7:0] sh_lo [16];
    logic [7:0] sh_hi [16];
    bit         v_lo  [16];
    bit         v_hi  [16];
    bit         ready_m = 0;
    logic [15:0] e_rdata;
    logic        e_lo, e_hi, e_ok;
    logic [1:0]  e_st;

    always #4 clk = ~clk;

    psram_ctrl_model #(.AW(AW), .DW(DW), .WAIT_CYCLES(WAITC)) i_psram_ctrl_model (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode(mode), .oe_n(oe_n),
        .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .drv_lo(drv_lo), .drv_hi(drv_hi), .rd_ok(rd_ok),
        .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " drv_lo"}, int'(drv_lo), int'(e_lo));
        chk({req, " drv_hi"}, int'(drv_hi), int'(e_hi));
        chk({req, " rdata"},  int'(rdata),  int'(e_rdata));
        chk({req, " rd_ok"},  int'(rd_ok),  int'(e_ok));
        chk({req, " status"}, int'(status), int'(e_st));
    endtask

    // One clock of stimulus; computes expectations from the requirements
    task automatic op(input bit cs, input bit md, input bit oe, input bit we,
                      input bit lb, input bit ub, input logic [3:0] a,
                      input logic [15:0] d);
        bit acc;
        cs_n = cs; mode = md; oe_n = oe; we_n = we; lb_n = lb; ub_n = ub;
        addr = a; wdata = d;
        acc  = ready_m && !cs && md;
        e_lo = acc && we && !oe && !lb;
        e_hi = acc && we && !oe && !ub;
        e_rdata = {(e_hi && v_hi[a]) ? sh_hi[a] : 8'h00,
                   (e_lo && v_lo[a]) ? sh_lo[a] : 8'h00};
        e_ok = (e_lo || e_hi) && (!e_lo || v_lo[a]) && (!e_hi || v_hi[a]);
        if (acc && !we) begin
            if (!lb) begin sh_lo[a] = d[7:0];  v_lo[a] = 1; end
            if (!ub) begin sh_hi[a] = d[15:8]; v_hi[a] = 1; end
        end
        if (ready_m) e_st = cs ? (md ? 2'd2 : 2'd3) : 2'd1;
        else         e_st = 2'd0;
        @(negedge clk);
    endtask

    task automatic idle();
        op(1, 1, 1, 1, 1, 1, 4'h0, 16'h0);
    endtask

    task automatic toggle();
        op(0, 1, 1, 1, 1, 1, 4'h0, 16'h0);
        op(1, 1, 1, 1, 1, 1, 4'h0, 16'h0);
    endtask

    task automatic wipe_model();
        for (int i = 0; i < 16; i++) begin v_lo[i] = 0; v_hi[i] = 0; end
    endtask

    task automatic recover(input string req);
        repeat (WAITC + 5) idle();
        chk({req, " still init after wait"}, int'(status), 0);
        toggle(); toggle();
        chk({req, " init after two dummy reads"}, int'(status), 0);
        toggle();
        chk({req, " ready after third dummy read"}, int'(status), 2);
        ready_m = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        wipe_model();
        rst_n = 0;
        cs_n = 1; mode = 1; oe_n = 1; we_n = 1; lb_n = 1; ub_n = 1;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(status), 0);
        chk("R1 drive", int'({drv_hi, drv_lo}), 0);
        chk("R1 rd_ok", int'(rd_ok), 0);
        rst_n = 1;

        // R2 accesses during init are ignored; early toggles do not count
        op(0, 1, 1, 0, 0, 0, 4'h1, 16'h1234);
        chk_all("R2 init write");
        op(0, 1, 0, 1, 0, 0, 4'h1, 16'h0);
        chk_all("R2 init read");
        idle();
        toggle(); toggle(); toggle();
        chk("R2 early toggles", int'(status), 0);
        recover("R2");

        // R2/R11: the init-time write was lost
        op(0, 1, 0, 1, 0, 0, 4'h1, 16'h0);
        chk_all("R2 R11 lost init write");
        chk("R7 active", int'(status), 1);

        // R3/R4 lane writes and reads
        op(0, 1, 1, 0, 0, 0, 4'h2, 16'hA5C3);
        op(0, 1, 0, 1, 0, 0, 4'h2, 16'h0);
        chk_all("R4 word read");
        chk("R4 word value", int'(rdata), 16'hA5C3);
        op(0, 1, 1, 0, 0, 1, 4'h2, 16'hEE11);
        op(0, 1, 1, 0, 1, 0, 4'h2, 16'h77DD);
        op(0, 1, 1, 0, 1, 1, 4'h2, 16'hFFFF);
        op(0, 1, 0, 1, 0, 0, 4'h2, 16'h0);
        chk_all("R3 lane writes and abort");
        chk("R3 merged value", int'(rdata), 16'h7711);
        op(0, 1, 0, 1, 0, 1, 4'h2, 16'h0);
        chk_all("R4 lower lane only");
        op(0, 1, 0, 1, 1, 0, 4'h2, 16'h0);
        chk_all("R4 upper lane only");
        // R5 output disable
        op(0, 1, 1, 1, 0, 0, 4'h2, 16'h0);
        chk_all("R5 output disable");
        // R6 write with oe low never drives
        op(0, 1, 0, 0, 0, 0, 4'h3, 16'h3C3C);
        chk_all("R6 write with oe low");
        op(0, 1, 0, 1, 0, 0, 4'h3, 16'h0);
        chk_all("R6 R3 readback");

        // Random phase (R3 R4 R5 R6 R7 R11)
        for (int i = 0; i < 400; i++) begin
            bit cs = ($urandom % 8) == 0;
            op(cs, 1, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
               4'($urandom), 16'($urandom));
            chk_all("R3 R4 R5 R6 R7 R11 random");
        end

        // R10 retention over standby
        op(0, 1, 1, 0, 0, 0, 4'h5, 16'hBEEF);
        repeat (6) begin
            idle();
            chk_all("R7 standby");
        end
        op(0, 1, 0, 1, 0, 0, 4'h5, 16'h0);
        chk_all("R10 retained word");
        chk("R10 value", int'(rdata), 16'hBEEF);

        // R8 deep standby, R9 recovery
        op(1, 0, 1, 1, 1, 1, 4'h0, 16'h0);
        chk("R8 deep status", int'(status), 3);
        ready_m = 0;
        wipe_model();
        op(1, 0, 1, 1, 1, 1, 4'h0, 16'h0);
        chk("R8 deep holds", int'(status), 3);
        idle();
        chk("R9 leave deep", int'(status), 0);
        recover("R9");
        op(0, 1, 0, 1, 0, 0, 4'h5, 16'h0);
        chk_all("R8 invalid after deep");
        op(0, 1, 1, 0, 0, 1, 4'h5, 16'h0042);
        op(0, 1, 0, 1, 0, 0, 4'h5, 16'h0);
        chk_all("R11 half valid word");
        op(0, 1, 0, 1, 0, 1, 4'h5, 16'h0);
        chk_all("R11 valid lower lane");

        // R9 mode low during init
        op(1, 0, 1, 1, 1, 1, 4'h0, 16'h0);
        ready_m = 0;
        wipe_model();
        idle();
        repeat (WAITC + 5) idle();
        toggle();
        op(1, 0, 1, 1, 1, 1, 4'h0, 16'h0);
        chk("R9 mode low during init", int'(status), 3);
        idle();
        chk("R9 back to init", int'(status), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule